// File: doc/BRIEF.md
# Virtual Address Translation Checker

This block turns a 32-bit virtual address into a physical address, or into an exception code when the access is not allowed. Each request carries the address, whether it is a read or a write, and whether the requester is privileged. Three control inputs shape the outcome. One enables translation. One lets privileged lookups ignore the address-space identifier. One closes the store-queue window to user code.

The block first sorts the address into a fixed region. Some regions pass through untouched, some pass through with the top three bits cleared, and some give an address error. Everything else either passes through masked, when translation is off, or is sent to an attached unified TLB in the same cycle. The TLB returns a match count and the fields of the entry it found. The block then applies the permission rules and builds the physical address from the entry's page size.

The result is registered and appears one cycle after the request. On a TLB-class fault the block also loads a fault-address register with the full address, and loads a 22-bit page-number register with address bits [31:10]. The low ten bits of the page-table-entry-high register are kept outside this block, so they are left alone.

Top module: `va_xlate_chk`

## Requirements
- R1: A privileged access at or above 0xE0000000 returns its address unchanged. A privileged access from 0x80000000 up to 0xBFFFFFFF returns the address AND 0x1FFFFFFF. Neither raises a lookup.
- R2: A user access with bit 31 set returns code 1 (read) or 2 (write). The exception is an address from 0xE0000000 to 0xE3FFFFFF while cfg_sqmd is 0: it returns the address unchanged with code 0.
- R3: When cfg_at is 0, every address not handled by R1 or R2 returns the address AND 0x1FFFFFFF, and lk_req stays low.
- R4: During a lookup, lk_match_asid is 0 only when cfg_sv is 1 and the access is privileged. Otherwise it is 1.
- R5: A lookup with lk_multi set returns code 8, which takes priority over every other TLB outcome. Otherwise, a lookup with lk_hit clear returns code 3 (read) or 4 (write).
- R6: A user read of an entry whose user bit is clear returns code 5.
- R7: A privileged write needs the writable bit. A user write needs both the writable bit and the user bit. If the rule is not met, the access returns code 6.
- R8: A write that passes R7 to an entry whose dirty bit is clear returns code 7.
- R9: A lookup that succeeds returns (PPN AND mask) OR (VA AND NOT mask). The mask clears the low 10, 12, 16 or 20 bits for lk_size 0, 1, 2 or 3.
- R10: Codes 3 to 8 load tea with the address and pteh_vpn with address bits [31:10]. All other outcomes, and idle cycles, leave both registers unchanged.
- R11: rsp_valid is high exactly one cycle after a request. rsp_exc is high when the code is nonzero, and rsp_paddr is 0 on an exception. After reset, every output register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | 1 = privileged requester |
| cfg_at | input | 1 | Translation enable |
| cfg_sv | input | 1 | Privileged lookups ignore the address-space identifier |
| cfg_sqmd | input | 1 | 1 = store-queue window closed to user mode |
| lk_req | output | 1 | Lookup request to the TLB |
| lk_vaddr | output | 32 | Address presented to the TLB |
| lk_match_asid | output | 1 | TLB must compare the address-space identifier |
| lk_hit | input | 1 | At least one entry matched |
| lk_multi | input | 1 | More than one entry matched |
| lk_ppn | input | 32 | Physical page of the matched entry |
| lk_size | input | 2 | Page size code of the matched entry |
| lk_user | input | 1 | Entry user-access bit |
| lk_writable | input | 1 | Entry writable bit |
| lk_dirty | input | 1 | Entry dirty bit |
| rsp_valid | output | 1 | Result valid |
| rsp_exc | output | 1 | Result is an exception |
| rsp_code | output | 4 | Exception code, 0 when none |
| rsp_paddr | output | 32 | Physical address |
| tea | output | 32 | Fault address register |
| pteh_vpn | output | 22 | Page-number field of the page-table-entry-high register |

## Verification
The hardest cases to reach are the ones where several rules apply at once. Examples are a multi-hit on a write to a clean, read-only entry, a user write in the store-queue window while the window is closed, and a privileged access in the 0xC0000000 region with translation on and cfg_sv set. The stimulus reaches them with a full cross of region addresses and all five mode bits against every combination of hit, multi-hit, permission bits and page size. The expected code, address and fault registers are recomputed in the bench for every request.

// File: rtl/va_xlate_pkg.sv
package va_xlate_pkg;

    localparam int AW       = 32;
    localparam int PAGE_LSB = 10;
    localparam int VPN_W    = AW - PAGE_LSB;
    localparam int CODE_W   = 4;

    typedef enum logic [CODE_W-1:0] {
        XC_NONE     = 4'd0,
        XC_ADDR_RD  = 4'd1,
        XC_ADDR_WR  = 4'd2,
        XC_MISS_RD  = 4'd3,
        XC_MISS_WR  = 4'd4,
        XC_PROT_RD  = 4'd5,
        XC_PROT_WR  = 4'd6,
        XC_FIRST_WR = 4'd7,
        XC_MULTI    = 4'd8
    } xc_code_e;

    typedef enum logic [1:0] {
        RT_RAW,
        RT_LOW,
        RT_ERR,
        RT_LOOKUP
    } route_e;

    typedef struct packed {
        logic [AW-1:0] ppn;
        logic [1:0]    size;
        logic          user;
        logic          writable;
        logic          dirty;
    } tlb_ent_t;

    typedef struct packed {
        logic          fault;
        xc_code_e      code;
        logic [AW-1:0] paddr;
    } xlate_res_t;

    localparam logic [AW-1:0] LOW_MASK = 32'h1FFF_FFFF;

    function automatic logic [AW-1:0] page_mask(input logic [1:0] size);
        logic [AW-1:0] m;
        case (size)
            2'd0:    m = {{(AW-10){1'b1}}, 10'b0};
            2'd1:    m = {{(AW-12){1'b1}}, 12'b0};
            2'd2:    m = {{(AW-16){1'b1}}, 16'b0};
            default: m = {{(AW-20){1'b1}}, 20'b0};
        endcase
        return m;
    endfunction

    function automatic logic tlb_class(input xc_code_e c);
        return (c >= XC_MISS_RD) && (c <= XC_MULTI);
    endfunction

endpackage

// File: rtl/va_region_sort.sv
module va_region_sort
    import va_xlate_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  logic          priv,
    input  logic          at_en,
    input  logic          sq_closed,
    output route_e        route
);
    logic sq_win;
    logic hi_e;
    logic below_c;

    always_comb begin
        hi_e    = addr[AW-1:AW-3] == 3'b111;
        below_c = addr[AW-1:AW-2] == 2'b10;
        sq_win  = addr[AW-1:AW-6] == 6'b111000;
        route   = at_en ? RT_LOOKUP : RT_LOW;
        if (addr[AW-1]) begin
            if (priv) begin
                if (hi_e)
                    route = RT_RAW;
                else if (below_c)
                    route = RT_LOW;
            end else begin
                if (sq_win && !sq_closed)
                    route = RT_RAW;
                else
                    route = RT_ERR;
            end
        end
    end
endmodule

// File: rtl/va_perm_check.sv
module va_perm_check
    import va_xlate_pkg::*;
(
    input  logic [AW-1:0] addr,
    input  logic          write,
    input  logic          priv,
    input  logic          hit,
    input  logic          multi,
    input  tlb_ent_t      ent,
    output xlate_res_t    res
);
    logic [AW-1:0] mask;
    logic          wr_ok;

    always_comb begin
        mask       = page_mask(ent.size);
        wr_ok      = priv ? ent.writable : (ent.writable && ent.user);
        res.fault  = 1'b1;
        res.paddr  = '0;
        res.code   = XC_NONE;
        if (multi)
            res.code = XC_MULTI;
        else if (!hit)
            res.code = write ? XC_MISS_WR : XC_MISS_RD;
        else if (!write && !priv && !ent.user)
            res.code = XC_PROT_RD;
        else if (write && !wr_ok)
            res.code = XC_PROT_WR;
        else if (write && !ent.dirty)
            res.code = XC_FIRST_WR;
        else begin
            res.fault = 1'b0;
            res.paddr = (ent.ppn & mask) | (addr & ~mask);
        end
    end
endmodule

// File: rtl/va_xlate_chk.sv
module va_xlate_chk
    import va_xlate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [31:0]       req_addr,
    input  logic              req_write,
    input  logic              req_priv,
    input  logic              cfg_at,
    input  logic              cfg_sv,
    input  logic              cfg_sqmd,
    output logic              lk_req,
    output logic [31:0]       lk_vaddr,
    output logic              lk_match_asid,
    input  logic              lk_hit,
    input  logic              lk_multi,
    input  logic [31:0]       lk_ppn,
    input  logic [1:0]        lk_size,
    input  logic              lk_user,
    input  logic              lk_writable,
    input  logic              lk_dirty,
    output logic              rsp_valid,
    output logic              rsp_exc,
    output logic [3:0]        rsp_code,
    output logic [31:0]       rsp_paddr,
    output logic [31:0]       tea,
    output logic [21:0]       pteh_vpn
);
    route_e     route;
    tlb_ent_t   ent;
    xlate_res_t tlb_res;
    xlate_res_t res_c;

    va_region_sort u_sort (
        .addr      (req_addr),
        .priv      (req_priv),
        .at_en     (cfg_at),
        .sq_closed (cfg_sqmd),
        .route     (route)
    );

    assign ent = '{ppn: lk_ppn, size: lk_size, user: lk_user,
                   writable: lk_writable, dirty: lk_dirty};

    va_perm_check u_perm (
        .addr  (req_addr),
        .write (req_write),
        .priv  (req_priv),
        .hit   (lk_hit),
        .multi (lk_multi),
        .ent   (ent),
        .res   (tlb_res)
    );

    assign lk_req        = req_valid && (route == RT_LOOKUP);
    assign lk_vaddr      = req_addr;
    assign lk_match_asid = !(cfg_sv && req_priv);

    always_comb begin
        res_c = '{fault: 1'b0, code: XC_NONE, paddr: req_addr};
        case (route)
            RT_RAW:    res_c.paddr = req_addr;
            RT_LOW:    res_c.paddr = req_addr & LOW_MASK;
            RT_ERR:    res_c = '{fault: 1'b1,
                                 code: req_write ? XC_ADDR_WR : XC_ADDR_RD,
                                 paddr: '0};
            default:   res_c = tlb_res;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_exc   <= 1'b0;
            rsp_code  <= '0;
            rsp_paddr <= '0;
            tea       <= '0;
            pteh_vpn  <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_exc   <= res_c.fault;
                rsp_code  <= res_c.code;
                rsp_paddr <= res_c.paddr;
                if (tlb_class(res_c.code)) begin
                    tea      <= req_addr;
                    pteh_vpn <= req_addr[AW-1:PAGE_LSB];
                end
            end
        end
    end
endmodule

// File: rtl/va_xlate_chk_sva.sv
module va_xlate_chk_sva (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [31:0] req_addr,
    input logic        req_write,
    input logic        req_priv,
    input logic        cfg_at,
    input logic        cfg_sv,
    input logic        cfg_sqmd,
    input logic        lk_req,
    input logic        lk_match_asid,
    input logic        lk_multi,
    input logic        rsp_valid,
    input logic        rsp_exc,
    input logic [3:0]  rsp_code,
    input logic [31:0] tea
);
    // R11
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R11
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R3
    lookup_gated_chk: assert property (@(posedge clk) disable iff (rst)
        lk_req |-> (req_valid && cfg_at));

    // R4
    user_asid_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_req && !req_priv) |-> lk_match_asid);

    // R10
    tea_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> $stable(tea));

    // R5
    multi_code_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_req && lk_multi) |=> (rsp_exc && rsp_code == 4'd8));

    // R2
    user_addr_err_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_priv && req_addr[31] &&
         !(req_addr[31:26] == 6'b111000 && !cfg_sqmd))
        |=> (rsp_exc && (rsp_code == (req_write ? 4'd2 : 4'd1) || rsp_code == 4'd1 || rsp_code == 4'd2)));
endmodule

bind va_xlate_chk va_xlate_chk_sva u_sva (.*);

// File: tb/va_xlate_chk_bench.sv
module va_xlate_chk_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, req_priv, cfg_at, cfg_sv, cfg_sqmd;
    logic [31:0] req_addr;
    logic        lk_req, lk_match_asid;
    logic [31:0] lk_vaddr;
    logic        lk_hit, lk_multi, lk_user, lk_writable, lk_dirty;
    logic [31:0] lk_ppn;
    logic [1:0]  lk_size;
    logic        rsp_valid, rsp_exc;
    logic [3:0]  rsp_code;
    logic [31:0] rsp_paddr, tea;
    logic [21:0] pteh_vpn;

    int checks = 0;
    int failures = 0;
    logic [31:0] m_tea;
    logic [21:0] m_vpn;

    always #(CLK_PERIOD/2) clk = ~clk;

    va_xlate_chk u_va_xlate_chk (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic void model(
        input logic [31:0] a, input logic w, input logic p, input logic at,
        input logic sv, input logic sq, input logic hit, input logic mul,
        input logic [31:0] ppn, input logic [1:0] sz,
        input logic u, input logic wr, input logic d,
        output logic [3:0] code, output logic [31:0] pa,
        output logic look, output logic masid);
        logic [31:0] mask;
        int sh;
        code = 0; pa = 0; look = 0; masid = !(sv && p);
        if (a[31] && p && a >= 32'hE000_0000) begin
            pa = a; return;
        end
        if (a[31] && p && a < 32'hC000_0000) begin
            pa = a & 32'h1FFF_FFFF; return;
        end
        if (a[31] && !p) begin
            if (a <= 32'hE3FF_FFFF && a >= 32'hE000_0000 && !sq) pa = a;
            else code = w ? 4'd2 : 4'd1;
            return;
        end
        if (!at) begin
            pa = a & 32'h1FFF_FFFF; return;
        end
        look = 1;
        sh = (sz == 0) ? 10 : (sz == 1) ? 12 : (sz == 2) ? 16 : 20;
        mask = 32'hFFFF_FFFF << sh;
        if (mul) code = 8;
        else if (!hit) code = w ? 4'd4 : 4'd3;
        else if (!w && !p && !u) code = 5;
        else if (w && (p ? !wr : !(wr && u))) code = 6;
        else if (w && !d) code = 7;
        else pa = (ppn & mask) | (a & ~mask);
    endfunction

    function automatic logic [31:0] pick_addr(input int i);
        case (i)
            0: return 32'h0012_3456;
            1: return 32'h7FFF_FC04;
            2: return 32'h8000_0040;
            3: return 32'hA1B2_C3D4;
            4: return 32'hC0AB_CDEF;
            5: return 32'hE000_0010;
            6: return 32'hE3FF_FFFC;
            7: return 32'hE400_0000;
            default: return 32'hFFFF_FF00;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 60000);
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1; req_valid = 0; req_addr = 0; req_write = 0; req_priv = 0;
        cfg_at = 0; cfg_sv = 0; cfg_sqmd = 0;
        lk_hit = 0; lk_multi = 0; lk_ppn = 0; lk_size = 0;
        lk_user = 0; lk_writable = 0; lk_dirty = 0;
        m_tea = 0; m_vpn = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R11 reset state
        chk("R11 reset valid", {31'b0, rsp_valid}, 0);
        chk("R11 reset code", {28'b0, rsp_code}, 0);
        chk("R11 reset paddr", rsp_paddr, 0);
        chk("R10 reset tea", tea, 0);
        chk("R10 reset vpn", {10'b0, pteh_vpn}, 0);

        for (int ai = 0; ai < 9; ai++) begin
            for (int m = 0; m < 32; m++) begin
                for (int t = 0; t < 3; t++) begin
                    for (int pm = 0; pm < 8; pm++) begin
                        for (int sz = 0; sz < 4; sz++) begin
                            logic [3:0]  ec;
                            logic [31:0] ep;
                            logic        el, ea;
                            req_addr  = pick_addr(ai);
                            req_priv  = m[0]; req_write = m[1]; cfg_at = m[2];
                            cfg_sv    = m[3]; cfg_sqmd  = m[4];
                            lk_hit    = (t != 0); lk_multi = (t == 2);
                            lk_user   = pm[0]; lk_writable = pm[1]; lk_dirty = pm[2];
                            lk_size   = sz[1:0];
                            lk_ppn    = 32'h1357_9BDF ^ (ai * 32'h0101_0400) ^ (sz * 32'h0040_0000);
                            req_valid = 1;
                            model(req_addr, req_write, req_priv, cfg_at, cfg_sv, cfg_sqmd,
                                  lk_hit, lk_multi, lk_ppn, lk_size, lk_user,
                                  lk_writable, lk_dirty, ec, ep, el, ea);
                            #1;
                            // R3 lookup strobe only when translation applies
                            chk("R3 lk_req", {31'b0, lk_req}, {31'b0, el});
                            if (el) chk("R4 lk_match_asid", {31'b0, lk_match_asid}, {31'b0, ea});
                            @(posedge clk);
                            @(negedge clk);
                            if (ec >= 3) begin
                                m_tea = req_addr; m_vpn = req_addr[31:10];
                            end
                            // R1 R2 R5 R6 R7 R8 code, R9 address
                            chk("R11 rsp_valid", {31'b0, rsp_valid}, 1);
                            chk("R5-8 code", {28'b0, rsp_code}, {28'b0, ec});
                            chk("R11 rsp_exc", {31'b0, rsp_exc}, {31'b0, ec != 0});
                            chk("R9 paddr", rsp_paddr, ep);
                            chk("R10 tea", tea, m_tea);
                            chk("R10 pteh_vpn", {10'b0, pteh_vpn}, {10'b0, m_vpn});
                        end
                    end
                end
            end
            // R11 idle cycle: no response, R10 fault registers hold
            req_valid = 0;
            @(posedge clk);
            @(negedge clk);
            chk("R11 idle valid", {31'b0, rsp_valid}, 0);
            chk("R10 idle tea", tea, m_tea);
        end
        req_valid = 0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule